// File: doc/BRIEF.md
# Acknowledge Polling Sequencer

After an I2C memory accepts a write, it runs an internal program cycle and stays off the bus until that cycle ends. The time the device actually needs is usually much shorter than its specified worst case. This sequencer does not wait out a fixed worst-case delay. Instead it probes the device over and over. Each probe is a START condition followed by the device select byte with the direction bit cleared. When the device acknowledges, the sequencer has both confirmed that the device is ready and sent the first byte of the next transfer.

The block sits above a byte-level I2C master engine and drives it through a small command/response pair. It sends a command code with a data byte and gets back one response for each command, carrying the acknowledge result. A requester loads a single request: a 7-bit device address, a memory address, a retry limit and the kind of follow-on access.

- For a write request, the sequencer sends the memory address and then hands the bus to the data phase.
- For a random read request, it sends the address, issues a repeated START and sends the device select byte with the direction bit set, then hands off.
- With no access pending, it releases the bus with STOP.
- If the device never answers within the retry budget, or refuses any later byte, it issues STOP and flags an error.

Top module: `ackpoll_seq`

## Requirements
- R1: While reset is applied, and once it is released, `busy`, `done`, `err` and `cmd_valid` are all low.
- R2: A request (`req_valid` high) is taken only while `busy` is low. `busy` rises in the cycle after the request is taken and stays high until the cycle in which `done` or `err` pulses. A `req_valid` pulse seen while `busy` is high changes nothing on the command stream.
- R3: Every poll attempt is a START command (code 0) followed by a WRITE command (code 3) whose data is the device address in bits 7:1 with bit 0 = 0.
- R4: If a poll select byte is not acknowledged and the retry budget is not used up, the next command is another START, which begins a new attempt.
- R5: The retry limit L (sampled with the request) allows L+1 poll attempts. A NACK on attempt L+1 leads to a STOP command (code 2) and an `err` pulse, with no `done`.
- R6: After a poll acknowledge with request kind "none" (`req_op` 0 or 3), the sequencer issues STOP and then pulses `done`.
- R7: After a poll acknowledge with request kind "write" (`req_op` 1), the sequencer sends the memory address as WRITE commands, most significant byte first. It pulses `done` after the last address byte is acknowledged and issues no STOP.
- R8: After a poll acknowledge with request kind "random read" (`req_op` 2), the sequencer sends the address bytes, then a RESTART command (code 1), then a WRITE of the device address with bit 0 = 1. It pulses `done` when that byte is acknowledged.
- R9: A NACK on any address byte, or on the read select byte, ends the sequence with STOP and an `err` pulse.
- R10: A command is held on `cmd_op` and `cmd_data` with `cmd_valid` high until `cmd_ready` accepts it. No further command is offered until the response for the accepted one arrives.
- R11: `done` and `err` are single-cycle pulses, never both high at once, and both occur with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Follow-on access: 0/3 none, 1 write, 2 random read |
| req_dev | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Memory address, sent most significant byte first |
| retry_limit | input | RETRY_W | Retries allowed after the first poll attempt |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulse: handoff or clean release |
| err | output | 1 | Pulse: retry budget exhausted or byte refused |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 START, 1 RESTART, 2 STOP, 3 WRITE byte |
| cmd_data | output | 8 | Byte for the WRITE command |
| rsp_valid | input | 1 | Response strobe for the outstanding command |
| rsp_ack | input | 1 | Acknowledge result of a WRITE byte |

## Verification
The assertions take three things for granted about the byte engine. It returns exactly one `rsp_valid` pulse for each accepted command. It never returns a response while no command is outstanding. It may hold `cmd_ready` low for any number of cycles. The bench engine model enforces this by keeping `cmd_ready` low while a command is pending and by raising a single response after a random delay of one to three cycles. The device model refuses a chosen number of poll attempts and may refuse one address byte or the read select byte, so both the retry loop and each error exit are reached from legal engine behaviour.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    CMD_START   = 2'd0,
    CMD_RESTART = 2'd1,
    CMD_STOP    = 2'd2,
    CMD_WRITE   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_START,
    S_POLL_SEL,
    S_ADDR,
    S_RESTART,
    S_RD_SEL,
    S_STOP
  } st_e;

endpackage

// File: rtl/ackpoll_rst_sync.sv
module ackpoll_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ackpoll_cmd_hs.sv
// Tracks the single outstanding command toward the byte engine.
module ackpoll_cmd_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic cmd_ready,
  input  logic rsp_valid,
  output logic cmd_valid,
  output logic take
);
  logic issued_q, issued_d;

  assign cmd_valid = want && !issued_q;
  assign take      = issued_q && rsp_valid;

  always_comb begin
    issued_d = issued_q;
    if (take)                        issued_d = 1'b0;
    else if (cmd_valid && cmd_ready) issued_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_q <= 1'b0;
    else        issued_q <= issued_d;
  end

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

// File: rtl/ackpoll_retry_ctr.sv
module ackpoll_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit_in,
  input  logic         bump,
  output logic         exhausted
);
  logic [W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic         en;

  assign exhausted = (cnt_q == lim_q);
  assign en        = load || (bump && !exhausted);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load) begin
      cnt_d = '0;
      lim_d = limit_in;
    end else if (bump && !exhausted) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/ackpoll_addr_sel.sv
// Presents the address one byte at a time, most significant first.
module ackpoll_addr_sel #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NB*8-1:0] addr_in,
  input  logic          adv,
  output logic [7:0]    byte_out,
  output logic          last
);
  localparam int AW = NB * 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  logic [AW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;

  assign byte_out = sh_q[AW-1 -: 8];
  assign last     = (idx_q == LAST_IDX);

  generate
    if (NB > 1) begin : g_multi
      always_comb begin
        sh_d  = load ? addr_in : {sh_q[AW-9:0], 8'h00};
        idx_d = load ? '0 : idx_q + 1'b1;
      end
    end else begin : g_single
      always_comb begin
        sh_d  = load ? addr_in : sh_q;
        idx_d = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load || adv) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int RETRY_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [6:0]              req_dev,
  input  logic [ADDR_BYTES*8-1:0] req_addr,
  input  logic [RETRY_W-1:0]      retry_limit,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [1:0]              cmd_op,
  output logic [7:0]              cmd_data,
  input  logic                    rsp_valid,
  input  logic                    rsp_ack
);
  logic srst_n;
  st_e  st_q, st_d;
  logic [1:0] op_q, op_d;
  logic [6:0] dev_q, dev_d;
  logic fail_q, fail_d, done_q, done_d, err_q, err_d;
  logic want, take, load, bump, adv, exhausted, last_byte, is_mem;
  cmd_e op_c;
  logic [7:0] dat_c, abyte;

  ackpoll_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  ackpoll_cmd_hs u_hs (
    .clk(clk), .rst_n(srst_n), .want(want), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .cmd_valid(cmd_valid), .take(take)
  );

  ackpoll_retry_ctr #(.W(RETRY_W)) u_retry (
    .clk(clk), .rst_n(srst_n), .load(load), .limit_in(retry_limit),
    .bump(bump), .exhausted(exhausted)
  );

  ackpoll_addr_sel #(.NB(ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(srst_n), .load(load), .addr_in(req_addr),
    .adv(adv), .byte_out(abyte), .last(last_byte)
  );

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign cmd_op   = op_c;
  assign cmd_data = dat_c;
  assign is_mem   = (op_q == OP_WRITE) || (op_q == OP_READ);

  // Command offered in each state
  always_comb begin
    want  = 1'b0;
    op_c  = CMD_START;
    dat_c = 8'h00;
    case (st_q)
      S_POLL_START: want = 1'b1;
      S_POLL_SEL:   begin want = 1'b1; op_c = CMD_WRITE; dat_c = {dev_q, 1'b0}; end
      S_ADDR:       begin want = 1'b1; op_c = CMD_WRITE; dat_c = abyte; end
      S_RESTART:    begin want = 1'b1; op_c = CMD_RESTART; end
      S_RD_SEL:     begin want = 1'b1; op_c = CMD_WRITE; dat_c = {dev_q, 1'b1}; end
      S_STOP:       begin want = 1'b1; op_c = CMD_STOP; end
      default:      want = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    dev_d  = dev_q;
    fail_d = fail_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    load   = 1'b0;
    bump   = 1'b0;
    adv    = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        load   = 1'b1;
        op_d   = req_op;
        dev_d  = req_dev;
        fail_d = 1'b0;
        st_d   = S_POLL_START;
      end
      S_POLL_START: if (take) st_d = S_POLL_SEL;
      S_POLL_SEL: if (take) begin
        if (rsp_ack)        st_d = is_mem ? S_ADDR : S_STOP;
        else if (exhausted) begin fail_d = 1'b1; st_d = S_STOP; end
        else                begin bump = 1'b1; st_d = S_POLL_START; end
      end
      S_ADDR: if (take) begin
        if (!rsp_ack)              begin fail_d = 1'b1; st_d = S_STOP; end
        else if (!last_byte)       adv = 1'b1;
        else if (op_q == OP_READ)  st_d = S_RESTART;
        else                       begin done_d = 1'b1; st_d = S_IDLE; end
      end
      S_RESTART: if (take) st_d = S_RD_SEL;
      S_RD_SEL: if (take) begin
        if (rsp_ack) begin done_d = 1'b1; st_d = S_IDLE; end
        else         begin fail_d = 1'b1; st_d = S_STOP; end
      end
      S_STOP: if (take) begin
        done_d = !fail_q;
        err_d  = fail_q;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= S_IDLE;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= 2'b00;
      dev_q  <= 7'h00;
    end else begin
      st_q   <= st_d;
      fail_q <= fail_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (load) begin
        op_q  <= op_d;
        dev_q <= dev_d;
      end
    end
  end

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R4
  retry_loop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == S_POLL_SEL && take && !rsp_ack && !exhausted) |=> (cmd_valid && cmd_op == CMD_START));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> $past(req_valid));

  // R11
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (done || err) |-> (!busy && !(done && err)));
endmodule

// File: tb/ackpoll_seq_bench.sv
`timescale 1ns/1ps
module ackpoll_seq_bench;
  localparam logic [1:0] C_START = 2'd0, C_RESTART = 2'd1, C_STOP = 2'd2, C_WRITE = 2'd3;
  localparam int K_OTHER = 0, K_POLL = 1, K_ADDR = 2, K_RSEL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [6:0] req_dev = 7'd0;
  logic [15:0] req_addr = 16'd0;
  logic [7:0] retry_limit = 8'd0;
  logic cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic busy, done, err, cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;

  int n_chk = 0, n_fail = 0;

  // device model configuration and command log
  int nack_polls = 0, addr_nack_at = -1, polls_seen = 0, addr_seen = 0;
  bit rsel_nack = 0;
  logic [1:0] prev_op = C_STOP;
  logic [1:0] lg_op [0:511];
  logic [7:0] lg_dat [0:511];
  int lg_n = 0;
  logic [1:0] ex_op [0:511];
  logic [7:0] ex_dat [0:511];
  int ex_n = 0;

  always #5 clk = ~clk;

  ackpoll_seq u_ackpoll_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_dev(req_dev), .req_addr(req_addr), .retry_limit(retry_limit),
    .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Byte engine and device model
  initial begin : engine
    int cnt, kind;
    bit pend, hold_seen;
    logic [1:0] pop, hop;
    logic [7:0] hdat;
    cnt = 0; kind = K_OTHER; pend = 0; hold_seen = 0; pop = 0; hop = 0; hdat = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; hold_seen = 0; cmd_ready = 0; rsp_valid = 0;
      end else begin
        if (rsp_valid) rsp_valid = 1'b0;
        if (pend) begin
          // R10: nothing further offered while a command is outstanding
          chk(!cmd_valid, "R10", "cmd_valid while outstanding", int'(cmd_valid), 0);
          cmd_ready = 1'b0;
          cnt--;
          if (cnt == 0) begin
            pend = 0;
            rsp_valid = 1'b1;
            case (kind)
              K_POLL: begin polls_seen++; rsp_ack = (polls_seen > nack_polls); end
              K_ADDR: begin rsp_ack = (addr_seen != addr_nack_at); addr_seen++; end
              K_RSEL: rsp_ack = !rsel_nack;
              default: rsp_ack = 1'b1;
            endcase
          end
        end else begin
          if (hold_seen) begin
            // R10: a stalled command stays put
            chk(cmd_valid && cmd_op == hop && cmd_data == hdat, "R10", "held command changed",
                int'({cmd_valid, cmd_op, cmd_data}), int'({1'b1, hop, hdat}));
          end
          cmd_ready = ($urandom_range(0, 3) != 0);
          hold_seen = cmd_valid && !cmd_ready;
          hop = cmd_op; hdat = cmd_data;
          if (cmd_valid && cmd_ready) begin
            if (lg_n < 512) begin lg_op[lg_n] = cmd_op; lg_dat[lg_n] = cmd_data; end
            lg_n++;
            pop = cmd_op;
            if (pop != C_WRITE)          kind = K_OTHER;
            else if (prev_op == C_START) kind = K_POLL;
            else if (prev_op == C_RESTART) kind = K_RSEL;
            else                         kind = K_ADDR;
            prev_op = pop;
            pend = 1;
            cnt = $urandom_range(1, 3);
          end
        end
      end
    end
  end

  task automatic push(input logic [1:0] o, input logic [7:0] d);
    ex_op[ex_n] = o; ex_dat[ex_n] = d; ex_n++;
  endtask

  // Expected command stream and outcome from the requirements
  task automatic build_exp(input logic [1:0] op, input logic [6:0] dev, input logic [15:0] addr,
                           input int nacks, input int lim, input int anack, input bit rnack,
                           output bit ok);
    ex_n = 0;
    ok = 1;
    for (int i = 0; i < 300; i++) begin
      push(C_START, 8'h00);
      push(C_WRITE, {dev, 1'b0});
      if (i < nacks) begin
        if (i == lim) begin push(C_STOP, 8'h00); ok = 0; return; end
      end else break;
    end
    if (op == 2'd1 || op == 2'd2) begin
      for (int b = 0; b < 2; b++) begin
        push(C_WRITE, (b == 0) ? addr[15:8] : addr[7:0]);
        if (b == anack) begin push(C_STOP, 8'h00); ok = 0; return; end
      end
      if (op == 2'd2) begin
        push(C_RESTART, 8'h00);
        push(C_WRITE, {dev, 1'b1});
        if (rnack) begin push(C_STOP, 8'h00); ok = 0; end
      end
    end else begin
      push(C_STOP, 8'h00);
    end
  endtask

  task automatic run_txn(input string tag, input logic [1:0] op, input logic [6:0] dev,
                         input logic [15:0] addr, input int nacks, input int lim,
                         input int anack, input bit rnack, input bit poke);
    bit eok;
    int t;
    build_exp(op, dev, addr, nacks, lim, anack, rnack, eok);
    nack_polls = nacks; addr_nack_at = anack; rsel_nack = rnack;
    polls_seen = 0; addr_seen = 0; lg_n = 0; prev_op = C_STOP;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_dev = dev; req_addr = addr; retry_limit = 8'(lim);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R2", "busy after request", int'(busy), 1);
    if (poke) begin
      // R2: request while busy must not disturb the stream
      req_valid = 1'b1; req_op = 2'd2; req_dev = ~dev; req_addr = ~addr;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!(done || err) && t < 3000) begin @(negedge clk); t++; end
    chk(done == eok && err == !eok, tag, "outcome done/err", int'({done, err}), int'({eok, !eok}));
    chk(!busy, "R11", "busy with result pulse", int'(busy), 0);
    @(negedge clk);
    chk(!done && !err, "R11", "result pulse width", int'({done, err}), 0);
    chk(lg_n == ex_n, tag, "command count", lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n; k++) begin
      chk(lg_op[k] == ex_op[k] && lg_dat[k] == ex_dat[k], tag, $sformatf("command %0d op/data", k),
          int'({lg_op[k], lg_dat[k]}), int'({ex_op[k], ex_dat[k]}));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(!busy && !done && !err && !cmd_valid, "R1", "outputs in reset",
        int'({busy, done, err, cmd_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !cmd_valid, "R1", "outputs after reset",
        int'({busy, done, err, cmd_valid}), 0);

    run_txn("R6",    2'd0, 7'h50, 16'h0000, 0, 0, -1, 0, 0);
    run_txn("R4/R7", 2'd1, 7'h51, 16'h12A5, 2, 5, -1, 0, 0);
    run_txn("R8",    2'd2, 7'h2C, 16'hBEEF, 1, 3, -1, 0, 0);
    run_txn("R5",    2'd1, 7'h33, 16'h0F0F, 3, 3, -1, 0, 0);  // last allowed attempt succeeds
    run_txn("R5",    2'd1, 7'h33, 16'h0F0F, 4, 3, -1, 0, 0);  // budget exhausted
    run_txn("R5",    2'd2, 7'h10, 16'h4321, 1, 0, -1, 0, 0);  // zero retries
    run_txn("R9",    2'd1, 7'h44, 16'hA55A, 0, 2,  1, 0, 0);
    run_txn("R9",    2'd2, 7'h45, 16'h5AA5, 1, 2, -1, 1, 0);
    run_txn("R2",    2'd3, 7'h7F, 16'hFFFF, 2, 4, -1, 0, 1);
    run_txn("R3",    2'd0, 7'h01, 16'h0001, 5, 5, -1, 0, 0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      int nk, lm, an;
      bit rn;
      op = 2'($urandom_range(0, 3));
      nk = $urandom_range(0, 5);
      lm = $urandom_range(0, 6);
      an = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 1) : -1;
      rn = ($urandom_range(0, 7) == 0);
      run_txn("R3/R4", op, 7'($urandom), 16'($urandom), nk, lm, an, rn, 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule